// File: doc/BRIEF.md
# Sign-Magnitude Subtractor

This block takes two unsigned operands of equal width and returns the difference `a - b` as a magnitude with a separate negative flag. Internally it negates the subtrahend into twos-complement form, adds that value to the minuend, and uses the carry out of the addition to choose the sign. A set carry means the raw sum is already the answer and the carry is simply dropped. A clear carry means the answer is negative, and the raw sum is negated a second time to recover the true magnitude.

Both negations use the same reusable combinational unit. It walks the operand from the least significant bit upward, passes bits through unchanged up to and including the lowest set bit, and inverts every bit above it. The inversion mask is a prefix OR of the lower bits. The unit also reports the carry that invert-plus-one would produce, which is set only for an all-zero input. The subtractor needs that carry when the subtrahend is zero. The whole path is combinational, so the outputs follow the inputs with no clock.

Top module: `sub_mag_unit`

## Requirements
- R1: The negator output equals `(~x + 1)` truncated to WIDTH bits for every WIDTH-bit input `x`. Its wrap flag is 1 exactly when `x` is all zeros.
- R2: In the negator output, every bit at or below the lowest set bit of `x` equals the input bit, and every bit above it is inverted. An all-zero input gives all zeros.
- R3: When `a_i >= b_i`, `neg_o` is 0 and `mag_o` equals `a_i - b_i`.
- R4: When `a_i < b_i`, `neg_o` is 1 and `mag_o` equals `b_i - a_i`.
- R5: When `a_i == b_i`, `mag_o` is 0 and `neg_o` is 0. A zero result is never flagged negative.
- R6: When `b_i` is 0, the result is positive and `mag_o` equals `a_i`. The sign is taken from the negator's wrap flag, because the adder itself produces no carry in this case.
- R7: When `a_i` is 0 and `b_i` is nonzero, `neg_o` is 1 and `mag_o` equals `b_i`.
- R8: At the operand extremes, the all-ones minus zero case gives the all-ones magnitude, positive. The zero minus all-ones case gives the all-ones magnitude, negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Minuend, unsigned |
| b_i | input | WIDTH | Subtrahend, unsigned |
| mag_o | output | WIDTH | Magnitude of a_i - b_i |
| neg_o | output | 1 | 1 when a_i - b_i is below zero |

## Verification
The delicate case is a zero subtrahend. Here the negated subtrahend is zero, the adder produces no carry, and the positive sign has to come from the negator's wrap flag instead. A correct magnitude alone does not show which path produced the sign. The stimulus sweeps every operand pair at width 4, so each of the sixteen minuends is paired with a zero subtrahend and the sign output is compared on each. The same sweep reaches equal operands, which must never report a negative zero. The negator is also driven on its own through all sixteen inputs, which checks the wrap flag directly.

// File: rtl/sub_mag_pkg.sv
package sub_mag_pkg;

    // Default operand width used when the top is elaborated alone.
    parameter int unsigned SMG_DEF_WIDTH = 8;

    // Sign of the final result.
    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;

endpackage

// File: rtl/sm_negate.sv
// Twos-complement negation by the copy-until-first-one rule.
// seen[i] is the OR of all input bits below i. Bit i is inverted when a
// lower bit is already set.
module sm_negate #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    output logic [WIDTH-1:0] y_o,
    output logic             wrap_o   // carry that invert-plus-one would produce
);

    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign seen[i+1] = seen[i] | x_i[i];
        assign y_o[i]    = x_i[i] ^ seen[i];
    end

    // Only an all-zero input carries out of the top bit.
    assign wrap_o = ~seen[WIDTH];

endmodule

// File: rtl/sm_ripple_add.sv
// Ripple-carry adder built from full-adder cells.
module sm_ripple_add #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] cy;

    assign cy[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic half;
        assign half     = a_i[i] ^ b_i[i];
        assign sum_o[i] = half ^ cy[i];
        assign cy[i+1]  = (a_i[i] & b_i[i]) | (half & cy[i]);
    end

    assign cout_o = cy[WIDTH];

endmodule

// File: rtl/sm_sign_fix.sv
// Turns the raw twos-complement sum into sign and magnitude.
module sm_sign_fix
    import sub_mag_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] sum_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);

    logic [WIDTH-1:0] sum_neg;
    logic             sum_zero;
    sign_e            sgn;

    sm_negate #(.WIDTH(WIDTH)) u_renegate (
        .x_i    (sum_i),
        .y_o    (sum_neg),
        .wrap_o (sum_zero)
    );

    // A zero raw sum is never reported as negative.
    assign sgn = (carry_i | sum_zero) ? SIGN_POS : SIGN_NEG;

    always_comb begin
        unique case (sgn)
            SIGN_POS: mag_o = sum_i;
            SIGN_NEG: mag_o = sum_neg;
            default:  mag_o = sum_i;
        endcase
    end

    assign neg_o = (sgn == SIGN_NEG);

endmodule

// File: rtl/sub_mag_unit.sv
// Unsigned subtractor with sign-magnitude result.
module sub_mag_unit
    import sub_mag_pkg::*;
#(
    parameter int unsigned WIDTH = SMG_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);

    logic [WIDTH-1:0] b_neg;
    logic             sub_zero;
    logic [WIDTH-1:0] raw_sum;
    logic             add_cout;
    logic             carry_eff;

    sm_negate #(.WIDTH(WIDTH)) u_neg_sub (
        .x_i    (b_i),
        .y_o    (b_neg),
        .wrap_o (sub_zero)
    );

    sm_ripple_add #(.WIDTH(WIDTH)) u_add (
        .a_i    (a_i),
        .b_i    (b_neg),
        .cin_i  (1'b0),
        .sum_o  (raw_sum),
        .cout_o (add_cout)
    );

    // Negating zero carries out of the word, and that carry joins the adder carry.
    assign carry_eff = add_cout | sub_zero;

    sm_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .sum_i   (raw_sum),
        .carry_i (carry_eff),
        .mag_o   (mag_o),
        .neg_o   (neg_o)
    );

endmodule

// File: rtl/sub_mag_checker.sv
module sub_mag_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] mag_o,
    input logic             neg_o,
    input logic [WIDTH-1:0] b_neg,
    input logic             sub_zero,
    input logic [WIDTH-1:0] raw_sum,
    input logic             add_cout
);

    logic [WIDTH-1:0] fwd_diff;
    logic [WIDTH-1:0] rev_diff;
    logic [WIDTH-1:0] inv_plus;

    assign fwd_diff = a_i - b_i;
    assign rev_diff = b_i - a_i;
    assign inv_plus = ~b_i + 1'b1;

    always_comb begin
        p_negate_r1: assert ((b_neg == inv_plus) && (sub_zero == (b_i == '0)))
            else $error("negator disagrees with invert-plus-one");
        p_raw_sum_r3: assert (raw_sum == fwd_diff)
            else $error("raw sum is not the modular difference");
        if (!neg_o) begin
            p_positive_r3: assert ((a_i >= b_i) && (mag_o == fwd_diff))
                else $error("positive result wrong");
        end
        if (neg_o) begin
            p_negative_r4: assert ((a_i < b_i) && (mag_o == rev_diff))
                else $error("negative result wrong");
        end
        if (a_i == b_i) begin
            p_equal_r5: assert ((mag_o == '0) && !neg_o)
                else $error("equal operands not zero");
        end
        if (b_i == '0) begin
            p_zero_sub_r6: assert (!neg_o && (mag_o == a_i))
                else $error("zero subtrahend wrong");
        end
        p_carry_excl_r6: assert (!(add_cout && sub_zero))
            else $error("adder and negator both carried");
    end

endmodule

bind sub_mag_unit sub_mag_checker #(.WIDTH(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .mag_o    (mag_o),
    .neg_o    (neg_o),
    .b_neg    (b_neg),
    .sub_zero (sub_zero),
    .raw_sum  (raw_sum),
    .add_cout (add_cout)
);

// File: tb/sub_mag_unit_bench.sv
module sub_mag_unit_bench;

    localparam int W    = 4;
    localparam int SPAN = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [W-1:0] a, b, mag;
    logic         neg;
    logic [W-1:0] nx, ny;
    logic         nwrap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    sub_mag_unit #(.WIDTH(W)) u_sub_mag_unit (
        .a_i (a), .b_i (b), .mag_o (mag), .neg_o (neg)
    );

    sm_negate #(.WIDTH(W)) u_sm_negate (
        .x_i (nx), .y_o (ny), .wrap_o (nwrap)
    );

    typedef struct {
        logic [W-1:0] ea;
        logic [W-1:0] eb;
        logic [W-1:0] emag;
        logic         eneg;
        string        tag;
    } item_t;

    item_t sb_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one operand pair and queues the expected result.
    task automatic drive_pair(input int av, input int bv);
        item_t it;
        int diff;
        @(posedge clk);
        a = av[W-1:0];
        b = bv[W-1:0];
        diff = av - bv;
        it.ea   = av[W-1:0];
        it.eb   = bv[W-1:0];
        it.eneg = (diff < 0);
        it.emag = (diff < 0) ? W'(-diff) : W'(diff);
        if ((av == SPAN-1 && bv == 0) || (av == 0 && bv == SPAN-1)) it.tag = "R8";
        else if (av == bv) it.tag = "R5";
        else if (bv == 0)  it.tag = "R6";
        else if (av == 0)  it.tag = "R7";
        else if (av > bv)  it.tag = "R3";
        else               it.tag = "R4";
        sb_q.push_back(it);
    endtask

    // Monitor: compares settled outputs half a cycle after each drive.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(mag == it.emag, it.tag, $sformatf("mag a=%0d b=%0d", it.ea, it.eb),
                  int'(mag), int'(it.emag));
            check(neg == it.eneg, it.tag, $sformatf("neg a=%0d b=%0d", it.ea, it.eb),
                  int'(neg), int'(it.eneg));
        end
    end

    initial begin
        a = '0; b = '0; nx = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero operands give zero, positive (R5)
        check(mag == '0, "R5", "reset mag", int'(mag), 0);
        check(neg == 1'b0, "R5", "reset neg", int'(neg), 0);

        // Negator alone, every input (R1, R2)
        for (int x = 0; x < SPAN; x++) begin
            logic [W-1:0] lowmask;
            logic [W-1:0] xv;
            @(posedge clk);
            nx = x[W-1:0];
            @(negedge clk);
            xv = x[W-1:0];
            check(ny == W'(SPAN - x), "R1", $sformatf("negate x=%0d", x),
                  int'(ny), (SPAN - x) % SPAN);
            check(nwrap == (x == 0), "R1", $sformatf("wrap x=%0d", x),
                  int'(nwrap), int'(x == 0));
            // bits through the lowest one are copied, bits above are flipped
            lowmask = (x == 0) ? '1 : (xv ^ (xv - 1'b1));
            check(((ny & lowmask) == (xv & lowmask)) && ((ny & ~lowmask) == (~xv & ~lowmask)),
                  "R2", $sformatf("copy rule x=%0d", x), int'(ny), int'(W'(SPAN - x)));
        end

        // Full subtractor, every operand pair (R3..R8)
        for (int ai = 0; ai < SPAN; ai++) begin
            for (int bi = 0; bi < SPAN; bi++) begin
                drive_pair(ai, bi);
            end
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule